// File: doc/BRIEF.md
# Clock-Chip Host Register Bank with Interrupt Flags

This block is the host-facing side of a real-time clock. A host reaches 128 bytes of byte-wide storage through just two locations. Writing the even location latches an index. Reading or writing the odd location accesses the byte that index selects. Four of those bytes are control registers:

- **A:** oscillator field, rate field and the update-in-progress flag.
- **B:** set mode and the interrupt enables.
- **C:** the interrupt flags, cleared when read.
- **D:** a fixed status byte.

Seven bytes hold the time and date, three hold alarm values, and the rest are plain storage.

The block does not count time itself. An external calendar counter supplies the current time bytes on `cnt_time` and steps when `cal_adv` pulses. It reloads from the register bytes when `cal_load` pulses. An external rate generator takes the rate field and enables and returns `per_tick`. Once per second `sec_req` starts an update sequence:

- UIP is raised and held for a number of 32 kHz timebase ticks.
- The calendar is then told to advance.
- On the following cycle the new time is captured, the alarm is compared and the update-ended event is raised.

All events gather into one active-high interrupt line.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, register A (index 10) reads 0x26, register B (index 11) reads 0x02, register C (index 12) reads 0x00, register D (index 13) reads 0x80, `irq` is low and the enable bits of B are clear.
- R2: A write with `host_sel`=0 latches bits 6:0 of the data as the index. Accesses with `host_sel`=1 write or read the indexed byte. A read with `host_sel`=0 returns 0xFF. General storage bytes (indexes 14 to 127) return what was written.
- R3: A write to register A stores bits 6:0 and leaves bit 7 (UIP) unchanged. `rate_sel` equals A bits 3:0.
- R4: Writes to register C and register D have no effect, and D always reads 0x80.
- R5: A write to B with bit 7 (SET) high forces UIP low. Writing B with SET low while SET was high pulses `cal_load` once. `cal_time` carries the time bytes in this order, lowest byte first: index 0 (seconds), 2 (minutes), 4 (hours), 6, 7, 8, 9.
- R6: A write to any time byte while SET is low pulses `cal_load` once, on the cycle after the write. Time-byte writes while SET is high, and writes to general bytes, do not pulse `cal_load`.
- R7: When A bits 6:4 equal 010, `sec_req` sets UIP on the next cycle. UIP is held for UIP_TICKS pulses of `tb_tick`. `cal_adv` pulses with the last tick. One cycle later `cnt_time` is copied into the time bytes unless SET is high, and UIP clears.
- R8: With UIE (B bit 4) set, each capture sets bits 7 and 4 of C (0x90).
- R9: With AIE (B bit 5) set, a capture sets bits 7 and 5 of C (0xA0) when each alarm byte (index 1, 3, 5) either has its top two bits both set or equals the new seconds, minutes or hours byte.
- R10: `per_tick` with PIE (B bit 6) set sets bits 7 and 6 of C (0xC0). Without PIE it sets nothing. `per_en` is PIE or SQWE (B bit 3), and `sqw_en` is SQWE.
- R11: A read of C returns its flags and clears them to 0x00. `irq` is the OR of (C bit 6 and PIE), (C bit 5 and AIE) and (C bit 4 and UIE).
- R12: If a flag is set in the same cycle that C is read, the read returns the earlier value and the new flag (with bit 7) remains afterwards.
- R13: When A bits 6:4 differ from 010, `sec_req` is ignored: UIP stays low and `cal_adv` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | 0 selects the index location, 1 the data location |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the current selection |
| irq | output | 1 | Interrupt request, active high |
| sec_req | input | 1 | One-second pulse that starts an update |
| tb_tick | input | 1 | 32 kHz timebase enable pulse |
| per_tick | input | 1 | Periodic event from the rate generator |
| rate_sel | output | 4 | Rate field for the rate generator |
| per_en | output | 1 | Rate generator run enable |
| sqw_en | output | 1 | Square-wave output enable |
| cnt_time | input | 56 | Current time bytes from the calendar counter |
| cal_adv | output | 1 | Advance the calendar by one second |
| cal_load | output | 1 | Load the calendar from `cal_time` |
| cal_time | output | 56 | Time bytes held in the register bank |

## Verification
Two functions can meet on one clock edge: the host's read of register C, which clears every flag, and an update capture, which sets the update-ended flag. The bench sets the periodic flag first, points the index at C, and times the data-location read to land exactly on the capture cycle, which is the cycle after the last timebase tick. It then judges the outcome twice. The collided read must return only the older periodic flags. A second read must show the update-ended flags that survived the clear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int IDX_A      = 10;
  localparam int IDX_B      = 11;
  localparam int IDX_C      = 12;
  localparam int IDX_D      = 13;
  localparam int TIME_BYTES = 7;

  localparam logic [6:0] A_LO_INIT = 7'h26;
  localparam logic [7:0] B_INIT    = 8'h02;
  localparam logic [7:0] D_FIXED   = 8'h80;

  localparam int B_SET  = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;

  typedef struct packed {
    logic irqf;
    logic pf;
    logic af;
    logic uf;
  } flags_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_CAPT} seq_state_e;

  // storage index of each calendar slot, slot 0 = seconds
  function automatic int time_idx(int slot);
    case (slot)
      0: return 0;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 7;
      5: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic logic is_time(int i);
    return (i == 0) || (i == 2) || (i == 4) || (i == 6) || (i == 7) || (i == 8) || (i == 9);
  endfunction
endpackage

// File: rtl/rtc_host_port.sv
module rtc_host_port #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [IDX_W-1:0] idx_data,
  output logic [IDX_W-1:0] idx,
  output logic             dwr,
  output logic             drd
);
  logic [IDX_W-1:0] idx_nxt;
  logic             idx_en;

  assign idx_en = wr & ~sel;

  always_comb begin
    idx_nxt = idx;
    if (idx_en) idx_nxt = idx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_nxt;
  end

  assign dwr = wr & sel;
  assign drd = rd & sel;
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_pkg::*;
#(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_req,
  input  logic tb_tick,
  input  logic osc_ok,
  input  logic set_mode,
  input  logic uip_clr,
  output logic uip,
  output logic cal_adv,
  output logic upd_end
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  seq_state_e       state, state_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             uip_nxt;

  assign cal_adv = (state == SEQ_WAIT) && tb_tick && (cnt == LAST);
  assign upd_end = (state == SEQ_CAPT);

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    uip_nxt   = uip;
    case (state)
      SEQ_IDLE: if (sec_req && osc_ok) begin
        state_nxt = SEQ_WAIT;
        cnt_nxt   = '0;
        uip_nxt   = ~set_mode;
      end
      SEQ_WAIT: if (tb_tick) begin
        if (cnt == LAST) state_nxt = SEQ_CAPT;
        else             cnt_nxt   = cnt + 1'b1;
      end
      default: begin
        state_nxt = SEQ_IDLE;
        uip_nxt   = 1'b0;
      end
    endcase
    if (uip_clr) uip_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      uip   <= 1'b0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
      uip   <= uip_nxt;
    end
  end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
  import rtc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set_pf,
  input  logic   set_af,
  input  logic   set_uf,
  input  logic   rd_clr,
  input  logic   pie,
  input  logic   aie,
  input  logic   uie,
  output flags_t flags,
  output logic   irq
);
  flags_t nxt;

  always_comb begin
    nxt = rd_clr ? '0 : flags;
    if (set_pf) nxt.pf = 1'b1;
    if (set_af) nxt.af = 1'b1;
    if (set_uf) nxt.uf = 1'b1;
    if (set_pf || set_af || set_uf) nxt.irqf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  assign irq = (flags.pf & pie) | (flags.af & aie) | (flags.uf & uie);
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int UIP_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        irq,
  input  logic        sec_req,
  input  logic        tb_tick,
  input  logic        per_tick,
  output logic [3:0]  rate_sel,
  output logic        per_en,
  output logic        sqw_en,
  input  logic [55:0] cnt_time,
  output logic        cal_adv,
  output logic        cal_load,
  output logic [55:0] cal_time
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] I_A = IDX_W'(IDX_A);
  localparam logic [IDX_W-1:0] I_B = IDX_W'(IDX_B);
  localparam logic [IDX_W-1:0] I_C = IDX_W'(IDX_C);
  localparam logic [IDX_W-1:0] I_D = IDX_W'(IDX_D);

  logic [IDX_W-1:0] idx;
  logic             dwr, drd;
  logic [6:0]       a_lo, a_lo_nxt;
  logic [7:0]       b_q, b_nxt;
  logic             load_q, load_nxt;
  logic             uip, upd_end, osc_ok, uip_clr, capture;
  logic             set_pf, set_af, set_uf, rd_clr, match;
  logic [2:0]       alm_hit;
  flags_t           flags;
  logic [7:0]       mem [DEPTH];

  rtc_host_port #(.IDX_W(IDX_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sel(host_sel), .wr(host_wr), .rd(host_rd),
    .idx_data(host_wdata[IDX_W-1:0]), .idx(idx), .dwr(dwr), .drd(drd)
  );

  // control register A/B next state
  always_comb begin
    a_lo_nxt = a_lo;
    b_nxt    = b_q;
    if (dwr && idx == I_A) a_lo_nxt = host_wdata[6:0];
    if (dwr && idx == I_B) b_nxt    = host_wdata;
  end

  assign load_nxt = (dwr && idx == I_B && b_q[B_SET] && !host_wdata[B_SET]) ||
                    (dwr && is_time(int'(idx)) && !b_q[B_SET]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lo   <= A_LO_INIT;
      b_q    <= B_INIT;
      load_q <= 1'b0;
    end else begin
      a_lo   <= a_lo_nxt;
      b_q    <= b_nxt;
      load_q <= load_nxt;
    end
  end

  assign osc_ok  = (a_lo[6:4] == 3'b010);
  assign uip_clr = dwr && idx == I_B && host_wdata[B_SET];

  rtc_update_seq #(.TICKS(UIP_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .sec_req(sec_req), .tb_tick(tb_tick),
    .osc_ok(osc_ok), .set_mode(b_q[B_SET]), .uip_clr(uip_clr),
    .uip(uip), .cal_adv(cal_adv), .upd_end(upd_end)
  );

  assign capture = upd_end && !b_q[B_SET];

  // alarm bytes sit just above seconds, minutes, hours
  for (genvar g = 0; g < 3; g++) begin : g_alarm
    localparam logic [IDX_W-1:0] AI = IDX_W'(2 * g + 1);
    assign alm_hit[g] = (mem[AI][7:6] == 2'b11) || (mem[AI] == cnt_time[8*g +: 8]);
  end
  assign match = &alm_hit;

  assign set_pf = per_tick && b_q[B_PIE];
  assign set_af = capture && b_q[B_AIE] && match;
  assign set_uf = capture && b_q[B_UIE];
  assign rd_clr = drd && idx == I_C;

  rtc_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .set_pf(set_pf), .set_af(set_af), .set_uf(set_uf),
    .rd_clr(rd_clr), .pie(b_q[B_PIE]), .aie(b_q[B_AIE]), .uie(b_q[B_UIE]),
    .flags(flags), .irq(irq)
  );

  // byte storage; capture overrides a same-cycle host write
  always_ff @(posedge clk) begin
    if (dwr && idx != I_A && idx != I_B && idx != I_C && idx != I_D)
      mem[idx] <= host_wdata;
    if (capture) begin
      for (int s = 0; s < TIME_BYTES; s++)
        mem[IDX_W'(time_idx(s))] <= cnt_time[8*s +: 8];
    end
  end

  for (genvar s = 0; s < TIME_BYTES; s++) begin : g_time
    assign cal_time[8*s +: 8] = mem[IDX_W'(time_idx(s))];
  end

  always_comb begin
    if (!host_sel) host_rdata = 8'hFF;
    else begin
      case (idx)
        I_A:     host_rdata = {uip, a_lo};
        I_B:     host_rdata = b_q;
        I_C:     host_rdata = {flags, 4'b0000};
        I_D:     host_rdata = D_FIXED;
        default: host_rdata = mem[idx];
      endcase
    end
  end

  assign cal_load = load_q;
  assign rate_sel = a_lo[3:0];
  assign per_en   = b_q[B_PIE] | b_q[B_SQWE];
  assign sqw_en   = b_q[B_SQWE];
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_sel,
  input logic             host_wr,
  input logic             host_rd,
  input logic [7:0]       host_wdata,
  input logic [7:0]       host_rdata,
  input logic [IDX_W-1:0] idx,
  input logic             uip,
  input logic             upd_end,
  input logic             osc_ok,
  input logic             sec_req,
  input logic             set_pf,
  input logic             set_af,
  input logic             set_uf,
  input logic             rd_clr,
  input logic [3:0]       flags,
  input logic [7:0]       b_q,
  input logic             irq
);
  AST_D_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_sel && idx == IDX_W'(13)) |-> host_rdata == 8'h80); // R4
  AST_SET_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && idx == IDX_W'(11) && host_wdata[7]) |=> !uip); // R5
  AST_UIP_END: assert property (@(posedge clk) disable iff (!rst_n)
    upd_end |=> !uip); // R7
  AST_UF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(b_q[4])); // R8
  AST_C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !set_pf && !set_af && !set_uf) |=> (flags == 4'b0000 && !irq)); // R11
  AST_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2:0] == 3'b000) |-> !irq); // R11
  AST_OSC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!uip && sec_req && !osc_ok && !upd_end) |=> !uip); // R13
endmodule

bind rtc_regbank rtc_regbank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .idx(idx), .uip(uip), .upd_end(upd_end), .osc_ok(osc_ok), .sec_req(sec_req),
  .set_pf(set_pf), .set_af(set_af), .set_uf(set_uf), .rd_clr(rd_clr),
  .flags(flags), .b_q(b_q), .irq(irq)
);

// File: tb/tb_rtc_regbank.sv
`timescale 1ns/1ps
module tb_rtc_regbank;
  localparam int TICKS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        irq, sec_req = 1'b0, tb_tick = 1'b0, per_tick = 1'b0;
  logic [3:0]  rate_sel;
  logic        per_en, sqw_en, cal_adv, cal_load;
  logic [55:0] cal_time;
  logic [55:0] cal_cnt = '0;
  int          n_adv = 0, n_load = 0;
  int          n_chk = 0, n_bad = 0;
  logic [7:0]  v;

  always #2.5 clk = ~clk;

  rtc_regbank #(.IDX_W(7), .UIP_TICKS(TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .sec_req(sec_req), .tb_tick(tb_tick), .per_tick(per_tick),
    .rate_sel(rate_sel), .per_en(per_en), .sqw_en(sqw_en),
    .cnt_time(cal_cnt), .cal_adv(cal_adv), .cal_load(cal_load), .cal_time(cal_time)
  );

  // calendar counter model: seconds byte steps by one
  always @(posedge clk) begin
    if (cal_load) begin
      cal_cnt <= cal_time;
      n_load  <= n_load + 1;
    end else if (cal_adv) begin
      cal_cnt[7:0] <= cal_cnt[7:0] + 8'h01;
      n_adv        <= n_adv + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); host_sel = s; host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); host_sel = 1'b1; host_rd = 1'b1; #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
    wr(1'b0, i); wr(1'b1, d);
  endtask

  task automatic reg_chk(input string req, input logic [7:0] i, input logic [7:0] exp);
    logic [7:0] d;
    wr(1'b0, i); rd(d);
    chk(req, d, exp);
  endtask

  task automatic tick();
    @(negedge clk); tb_tick = 1'b1;
    @(negedge clk); tb_tick = 1'b0;
  endtask

  task automatic start_upd();
    @(negedge clk); sec_req = 1'b1;
    @(negedge clk); sec_req = 1'b0;
  endtask

  task automatic finish_upd();
    repeat (TICKS) tick();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulse_per();
    @(negedge clk); per_tick = 1'b1;
    @(negedge clk); per_tick = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int a0, l0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    reg_chk("R1 A", 8'd10, 8'h26);
    reg_chk("R1 B", 8'd11, 8'h02);
    reg_chk("R1 C", 8'd12, 8'h00);
    reg_chk("R1 D", 8'd13, 8'h80);
    chk("R1 irq", irq, 1'b0);
    chk("R10 rate_sel", rate_sel, 4'h6);
    chk("R10 per_en/sqw_en", {per_en, sqw_en}, 2'b00);

    // R2 sweep general bytes, index written with bit 7 set
    for (int i = 14; i < 128; i++) reg_wr(8'(i) | 8'h80, 8'((i * 7 + 3) & 255));
    for (int i = 14; i < 128; i++) reg_chk("R2 storage", 8'(i), 8'((i * 7 + 3) & 255));
    @(negedge clk); host_sel = 1'b0; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
    chk("R2 index read", v, 8'hFF);

    // R3 register A
    reg_wr(8'd10, 8'hFF);
    reg_chk("R3 A uip kept", 8'd10, 8'h7F);
    chk("R3 rate_sel", rate_sel, 4'hF);
    reg_wr(8'd10, 8'h26);

    // R4 C and D ignore writes
    reg_wr(8'd13, 8'h00);
    reg_chk("R4 D", 8'd13, 8'h80);
    reg_wr(8'd12, 8'hFF);
    reg_chk("R4 C", 8'd12, 8'h00);
    chk("R4 irq", irq, 1'b0);

    // R6 time writes reload the calendar
    l0 = n_load;
    reg_wr(8'd0, 8'h10);
    reg_wr(8'd2, 8'h20);
    reg_wr(8'd4, 8'h05);
    @(negedge clk);
    chk("R6 loads", n_load - l0, 3);
    chk("R6 cal low bytes", cal_cnt[23:0], 24'h052010);
    l0 = n_load;
    reg_wr(8'd20, 8'h77);
    @(negedge clk);
    chk("R6 general no load", n_load - l0, 0);

    // R7 R8 update cycle with UIE
    reg_wr(8'd11, 8'h12);
    a0 = n_adv;
    start_upd();
    reg_chk("R7 uip high", 8'd10, 8'hA6);
    finish_upd();
    chk("R7 adv", n_adv - a0, 1);
    reg_chk("R7 sec captured", 8'd0, 8'h11);
    reg_chk("R7 uip low", 8'd10, 8'h26);
    chk("R8 irq", irq, 1'b1);
    reg_chk("R8 C", 8'd12, 8'h90);
    chk("R11 irq cleared", irq, 1'b0);
    reg_chk("R11 C cleared", 8'd12, 8'h00);

    // R9 alarm
    reg_wr(8'd11, 8'h22);
    reg_wr(8'd1, 8'h12); reg_wr(8'd3, 8'hC0); reg_wr(8'd5, 8'h05);
    start_upd(); finish_upd();
    chk("R9 irq", irq, 1'b1);
    reg_chk("R9 match", 8'd12, 8'hA0);
    reg_wr(8'd1, 8'h40); reg_wr(8'd3, 8'h20); reg_wr(8'd5, 8'hC0);
    start_upd(); finish_upd();
    reg_chk("R9 mismatch", 8'd12, 8'h00);
    reg_wr(8'd1, 8'hFF); reg_wr(8'd3, 8'hC0); reg_wr(8'd5, 8'hC5);
    start_upd(); finish_upd();
    reg_chk("R9 dont care", 8'd12, 8'hA0);
    reg_chk("R9 sec", 8'd0, 8'h14);

    // R10 periodic
    reg_wr(8'd11, 8'h02);
    pulse_per();
    reg_chk("R10 no PIE", 8'd12, 8'h00);
    reg_wr(8'd11, 8'h42);
    chk("R10 per_en", {per_en, sqw_en}, 2'b10);
    pulse_per();
    chk("R10 irq", irq, 1'b1);
    reg_chk("R10 PF", 8'd12, 8'hC0);
    reg_wr(8'd11, 8'h0A);
    chk("R10 sqw", {per_en, sqw_en}, 2'b11);

    // R5 set mode
    reg_wr(8'd11, 8'h02);
    start_upd();
    reg_chk("R5 uip before", 8'd10, 8'hA6);
    reg_wr(8'd11, 8'h82);
    reg_chk("R5 uip forced low", 8'd10, 8'h26);
    finish_upd();
    reg_chk("R5 no copy in set", 8'd0, 8'h14);
    chk("R5 counter advanced", cal_cnt[7:0], 8'h15);
    l0 = n_load;
    reg_wr(8'd0, 8'h30);
    @(negedge clk);
    chk("R6 no load in set", n_load - l0, 0);
    reg_wr(8'd11, 8'h02);
    @(negedge clk);
    chk("R5 load on set clear", n_load - l0, 1);
    chk("R5 loaded sec", cal_cnt[7:0], 8'h30);

    // R12 read of C collides with capture
    reg_wr(8'd11, 8'h52);
    pulse_per();
    wr(1'b0, 8'd12);
    start_upd();
    repeat (TICKS - 1) tick();
    @(negedge clk); tb_tick = 1'b1;
    @(negedge clk); tb_tick = 1'b0; host_sel = 1'b1; host_rd = 1'b1; #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
    chk("R12 old value", v, 8'hC0);
    chk("R12 irq kept", irq, 1'b1);
    reg_chk("R12 new flag kept", 8'd12, 8'h90);
    reg_chk("R12 sec", 8'd0, 8'h31);

    // R13 oscillator stopped
    reg_wr(8'd11, 8'h02);
    reg_wr(8'd10, 8'h06);
    a0 = n_adv;
    start_upd();
    reg_chk("R13 no uip", 8'd10, 8'h06);
    finish_upd();
    chk("R13 no adv", n_adv - a0, 0);
    reg_chk("R13 sec", 8'd0, 8'h31);
    reg_wr(8'd10, 8'h26);

    // R1 reset mid-run
    reg_wr(8'd11, 8'h7A);
    pulse_per();
    chk("R1 pre irq", irq, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R1 irq async", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    reg_chk("R1 B after reset", 8'd11, 8'h02);
    reg_chk("R1 C after reset", 8'd12, 8'h00);
    reg_chk("R1 A after reset", 8'd10, 8'h26);

    summary();
    $finish;
  end
endmodule